// File: doc/BRIEF.md
# Dual-Style Serial 0101 Detector

This block watches a one-bit serial stream and raises a flag on every occurrence of the bit sequence 0, 1, 0, 1. Overlapping matches count. The stream is qualified by a sample-valid strobe, and a bit is consumed only on a rising clock edge when the strobe is high.

Two independent state machines share the same input and produce the two outputs. The first is a four-state machine whose flag is combinational. It depends on the present state and the present bit, so it rises during the sample that completes the pattern. The second is a five-state machine whose flag is a registered function of its state alone. It rises one accepted sample later. Both state codes are brought out so that the sequencing can be observed at the ports.

A thin top wires a control unit to a datapath. The control unit turns reset and the strobe into a small struct of strobes. The datapath holds the two machines.

Top module: `pattern_detector_top`

## Requirements
- R1: While reset is high and on the first cycle after it falls, both state outputs read 0 (state A) and both flags read 0.
- R2: The four-state machine uses codes A=0, B=1, C=2, D=3. On each accepted bit it moves as follows:
  - From A, a 0 goes to B and a 1 stays in A.
  - From B, a 0 stays in B and a 1 goes to C.
  - From C, a 0 goes to D and a 1 goes to A.
  - From D, a 0 goes to B and a 1 goes to C.
- R3: `mealyHit` is 1 in a cycle exactly when the strobe is high, the four-state machine is in D and the serial bit is 1. It is 0 otherwise, in the same cycle as the inputs.
- R4: The five-state machine uses codes A=0, B=1, C=2, D=3, E=4 and only ever shows those codes. On each accepted bit it moves as follows:
  - From A, a 0 goes to B and a 1 stays in A.
  - From B, a 0 stays in B and a 1 goes to C.
  - From C, a 0 goes to D and a 1 goes to A.
  - From D, a 0 goes to B and a 1 goes to E.
  - From E, a 0 goes to D and a 1 goes to A.
- R5: `mooreHit` is registered and reads 1 exactly while the five-state machine is in E.
- R6: Matches overlap. The stream 0,1,0,1,0,1 flags on its fourth and sixth accepted bits. After a hit, the four-state machine sits in C.
- R7: With the strobe low, both states and `mooreHit` hold their values and `mealyHit` reads 0, whatever the serial bit is.
- R8: For every accepted sample on which `mealyHit` is 1, `mooreHit` is 1 after that clock edge. `mooreHit` never rises without such a sample.
- R9: Reset takes priority over a high strobe. During reset no bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Qualifies serialBit for this edge |
| serialBit | input | 1 | Serial data bit |
| mealyHit | output | 1 | Combinational match flag from the four-state machine |
| mooreHit | output | 1 | Registered match flag from the five-state machine |
| mealyState | output | 2 | Four-state machine code |
| mooreState | output | 3 | Five-state machine code |

## Verification
The hardest situation to reach is a match whose bits are spread across idle cycles, where the machines must hold in D while a low-strobe 1 is presented. That cycle must give no flag, and the delayed flag must not shift. Directed tasks place invalid cycles with both bit values inside partial patterns. Random streams with random strobe gaps are then compared against a model that shifts in only the accepted bits. That model also predicts the one-sample lag of the registered flag.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  localparam int MEALY_W = 2;
  localparam int MOORE_W = 3;

  typedef enum logic [MEALY_W-1:0] {
    ML_A = 2'd0, ML_B = 2'd1, ML_C = 2'd2, ML_D = 2'd3
  } mealySt_t;

  typedef enum logic [MOORE_W-1:0] {
    MR_A = 3'd0, MR_B = 3'd1, MR_C = 3'd2, MR_D = 3'd3, MR_E = 3'd4
  } mooreSt_t;

  typedef struct packed {
    logic advance;
    logic clear;
  } pdStrobe_t;
endpackage

// File: rtl/pd_ctrl.sv
`timescale 1ns/1ps
module pd_ctrl
  import pd_pkg::*;
(
  input  logic      rst,
  input  logic      sampleValid,
  output pdStrobe_t strobe
);
  // Reset dominates: no bit is consumed while clear is asserted.
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = sampleValid & ~rst;
  end
endmodule

// File: rtl/pd_mealy.sv
`timescale 1ns/1ps
module pd_mealy
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pdStrobe_t strobe,
  input  logic      serialBit,
  output mealySt_t  state,
  output logic      hit
);
  mealySt_t nextState;

  always_comb begin
    case (state)
      ML_A:    nextState = serialBit ? ML_A : ML_B;
      ML_B:    nextState = serialBit ? ML_C : ML_B;
      ML_C:    nextState = serialBit ? ML_A : ML_D;
      ML_D:    nextState = serialBit ? ML_C : ML_B;
      default: nextState = ML_A;
    endcase
  end

  assign hit = strobe.advance & serialBit & (state == ML_D);

  always_ff @(posedge clk) begin
    if (strobe.clear)        state <= ML_A;
    else if (strobe.advance) state <= nextState;
  end

  // After a hit the trailing "01" is retained.
  assert_overlap_keeps_c_R6: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state == ML_C));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.clear) |=> $stable(state));
endmodule

// File: rtl/pd_moore.sv
`timescale 1ns/1ps
module pd_moore
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pdStrobe_t strobe,
  input  logic      serialBit,
  output mooreSt_t  state,
  output logic      hit
);
  mooreSt_t nextState;

  always_comb begin
    case (state)
      MR_A:    nextState = serialBit ? MR_A : MR_B;
      MR_B:    nextState = serialBit ? MR_C : MR_B;
      MR_C:    nextState = serialBit ? MR_A : MR_D;
      MR_D:    nextState = serialBit ? MR_E : MR_B;
      MR_E:    nextState = serialBit ? MR_A : MR_D;
      default: nextState = MR_A;   // unused codes fall back to idle
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      state <= MR_A;
      hit   <= 1'b0;
    end else if (strobe.advance) begin
      state <= nextState;
      hit   <= (nextState == MR_E);
    end
  end

  assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
    state <= MR_E);

  assert_flag_tracks_e_R5: assert property (@(posedge clk) disable iff (rst)
    hit == (state == MR_E));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.clear) |=> ($stable(hit) && $stable(state)));
endmodule

// File: rtl/pd_datapath.sv
`timescale 1ns/1ps
module pd_datapath
  import pd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pdStrobe_t          strobe,
  input  logic               serialBit,
  output logic               mealyHit,
  output logic               mooreHit,
  output logic [MEALY_W-1:0] mealyState,
  output logic [MOORE_W-1:0] mooreState
);
  mealySt_t mealySt;
  mooreSt_t mooreSt;

  pd_mealy mealy_i (
    .clk(clk), .rst(rst), .strobe(strobe), .serialBit(serialBit),
    .state(mealySt), .hit(mealyHit)
  );

  pd_moore moore_i (
    .clk(clk), .rst(rst), .strobe(strobe), .serialBit(serialBit),
    .state(mooreSt), .hit(mooreHit)
  );

  assign mealyState = mealySt;
  assign mooreState = mooreSt;

  // The registered flag trails the combinational one by one accepted sample.
  assert_lag_follow_R8: assert property (@(posedge clk) disable iff (rst)
    mealyHit |=> mooreHit);

  assert_lag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mooreHit) |-> $past(mealyHit));
endmodule

// File: rtl/pattern_detector_top.sv
`timescale 1ns/1ps
module pattern_detector_top
  import pd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleValid,
  input  logic               serialBit,
  output logic               mealyHit,
  output logic               mooreHit,
  output logic [MEALY_W-1:0] mealyState,
  output logic [MOORE_W-1:0] mooreState
);
  pdStrobe_t strobe;

  pd_ctrl ctrl_i (
    .rst(rst), .sampleValid(sampleValid), .strobe(strobe)
  );

  pd_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .serialBit(serialBit),
    .mealyHit(mealyHit), .mooreHit(mooreHit),
    .mealyState(mealyState), .mooreState(mooreState)
  );

  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> (mealyState == 2'd0 && mooreState == 3'd0 && !mooreHit));
endmodule

// File: tb/pattern_detector_top_tb_top.sv
`timescale 1ns/1ps
module pattern_detector_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sampleValid = 1'b0;
  logic       serialBit = 1'b0;
  logic       mealyHit, mooreHit;
  logic [1:0] mealyState;
  logic [2:0] mooreState;

  int checkCount = 0;
  int failCount  = 0;

  logic [2:0] refHist  = 3'b000;
  int         refCount = 0;
  logic       refMoore = 1'b0;

  always #5 clk = ~clk;

  pattern_detector_top dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .serialBit(serialBit),
    .mealyHit(mealyHit), .mooreHit(mooreHit),
    .mealyState(mealyState), .mooreState(mooreState)
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One sample: drive mid-cycle, check the combinational flag,
  // then check the registered flag after the edge.
  task automatic step(input logic v, input logic b, input string tag);
    logic expMealy;
    @(negedge clk);
    sampleValid = v;
    serialBit   = b;
    #1;
    expMealy = v && (refCount >= 3) && ({refHist, b} == 4'b0101);
    chk({tag, " R3 mealyHit"}, int'(mealyHit), int'(expMealy));
    @(posedge clk);
    #1;
    if (v) begin
      refMoore = expMealy;
      refHist  = {refHist[1:0], b};
      if (refCount < 3) refCount++;
    end
    chk({tag, " R8 mooreHit"}, int'(mooreHit), int'(refMoore));
  endtask

  task automatic stepS(input logic v, input logic b, input int expMl, input int expMr,
                       input string tag);
    step(v, b, tag);
    chk({tag, " R2 mealyState"}, int'(mealyState), expMl);
    chk({tag, " R4 mooreState"}, int'(mooreState), expMr);
    chk({tag, " R5 mooreHit vs E"}, int'(mooreHit), int'(expMr == 4));
  endtask

  task automatic doReset(input logic validDuring);
    @(negedge clk);
    rst = 1'b1;
    sampleValid = validDuring;
    serialBit = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 mealyState in reset", int'(mealyState), 0);
    chk("R1 mooreState in reset", int'(mooreState), 0);
    chk("R1 mooreHit in reset", int'(mooreHit), 0);
    chk("R9 mealyHit in reset", int'(mealyHit), 0);
    @(negedge clk);
    serialBit = 1'b1;
    #1;
    chk("R9 mealyHit with strobe during reset", int'(mealyHit), 0);
    @(posedge clk);
    #1;
    chk("R9 no bit consumed during reset", int'(mooreState), 0);
    @(negedge clk);
    rst = 1'b0;
    sampleValid = 1'b0;
    refHist = 3'b000;
    refCount = 0;
    refMoore = 1'b0;
    #1;
    chk("R1 mealyState after reset", int'(mealyState), 0);
    chk("R1 mealyHit after reset", int'(mealyHit), 0);
  endtask

  task automatic testTransitions();
    doReset(1'b0);
    stepS(1, 1, 0, 0, "A on 1");
    stepS(1, 0, 1, 1, "A on 0");
    stepS(1, 0, 1, 1, "B on 0");
    stepS(1, 1, 2, 2, "B on 1");
    stepS(1, 1, 0, 0, "C on 1");
    stepS(1, 0, 1, 1, "to B");
    stepS(1, 1, 2, 2, "to C");
    stepS(1, 0, 3, 3, "C on 0");
    stepS(1, 0, 1, 1, "D on 0");
  endtask

  task automatic testOverlap();
    doReset(1'b0);
    stepS(1, 0, 1, 1, "R6 b1");
    stepS(1, 1, 2, 2, "R6 b2");
    stepS(1, 0, 3, 3, "R6 b3");
    stepS(1, 1, 2, 4, "R6 first hit");
    stepS(1, 0, 3, 3, "R6 E on 0");
    stepS(1, 1, 2, 4, "R6 second hit");
    stepS(1, 1, 0, 0, "R6 E on 1");
  endtask

  task automatic testGaps();
    doReset(1'b0);
    stepS(1, 0, 1, 1, "R7 b1");
    stepS(0, 1, 1, 1, "R7 gap after b1");
    stepS(1, 1, 2, 2, "R7 b2");
    stepS(1, 0, 3, 3, "R7 b3");
    stepS(0, 1, 3, 3, "R7 gap in D with 1");
    stepS(0, 0, 3, 3, "R7 gap in D with 0");
    stepS(1, 1, 2, 4, "R7 hit after gaps");
    stepS(0, 1, 2, 4, "R7 moore holds");
    stepS(0, 0, 2, 4, "R7 moore holds again");
    stepS(1, 0, 3, 3, "R7 resume");
  endtask

  task automatic testRandom(input int n, input int validPct);
    doReset(1'b1);
    for (int i = 0; i < n; i++) begin
      logic v, b;
      v = ($urandom_range(99) < validPct);
      b = $urandom_range(1);
      step(v, b, "R6 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    testTransitions();
    testOverlap();
    testGaps();
    testRandom(3000, 100);
    testRandom(3000, 60);
    testRandom(2000, 25);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule